// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the host-facing side of an embedded controller. It has a data port and a port that is shared between status (when read) and command (when written). A host writes a command byte, then writes the bytes that the command needs. Before each byte it polls the input-full flag until the flag is clear. When a result is ready, the block puts it in the data register and raises the output-full flag. The host polls for that flag and then reads the data port. Five commands are decoded: read a register, write a register, enable burst, disable burst, and fetch the lowest pending event. Reads and writes reach a 256-byte register space through an address/data/strobe interface. A third host port holds interrupt enables and a clear control for the system-management event.

After the block accepts a host byte, the byte is held for `PROC_DLY` clocks and then consumed by the sequencer. The sequencer has five states:
- `S_IDLE`: no command in progress.
- `S_RD_ADDR`: a read command was consumed and the block is waiting for its address byte.
- `S_RD_FETCH`: a one-cycle register read is in progress.
- `S_WR_ADDR`: a write command was consumed and the block is waiting for its address byte.
- `S_WR_DATA`: the block is waiting for the data byte of a write.

The transitions are:
- Any consumed command byte restarts the sequencer. Read goes to `S_RD_ADDR`, write goes to `S_WR_ADDR`, and every other command goes to `S_IDLE`.
- A data byte consumed in `S_RD_ADDR` goes to `S_RD_FETCH`.
- A data byte consumed in `S_WR_ADDR` goes to `S_WR_DATA`.
- A data byte consumed in `S_WR_DATA` goes to `S_IDLE`.
- `S_RD_FETCH` always returns to `S_IDLE` after one cycle.

Host port select codes are 0 for data, 1 for status/command and 2 for interrupt control.

Top module: `ec_host_port`

## Requirements
- R1: After reset the status byte, the data register, the interrupt control read-back, `sci_irq` and `smi_irq` are all zero.
- R2: A host write to the data or command port with input-full (status bit 1) clear is accepted. Input-full is then high for exactly `PROC_DLY` cycles. A data or command write that arrives while input-full is high is dropped.
- R3: Status bit 3 is 1 when the last accepted byte came through the command port and 0 when it came through the data port.
- R4: Command 0x80 followed by an address byte issues one `reg_re` strobe at that address. The value returned is placed in the data register, and output-full (status bit 0) is set.
- R5: A host read of the data port clears output-full, unless a new result is loaded in the same cycle.
- R6: Command 0x81 followed by an address byte and a data byte issues exactly one `reg_we` strobe carrying that address and data. `reg_we` and `reg_re` are never high together.
- R7: Command 0x82 sets the burst flag (status bit 4), and command 0x83 clears it.
- R8: Command 0x84 loads the number of the lowest pending event into the data register and removes that event. Event input bit i has number i+1. When nothing is pending the command loads 0. In both cases output-full is set.
- R9: Status bit 5 is 1 while any event is pending. `sci_irq` is that bit gated by interrupt control bit 0.
- R10: A `smi_raise` pulse sets status bit 6. A write to interrupt control with bit 2 set clears status bit 6. `smi_irq` is status bit 6 gated by interrupt control bit 1. Interrupt control reads back bits 1:0 only.
- R11: A data-port byte consumed in `S_IDLE` is ignored: there is no register strobe and output-full does not change.
- R12: A command byte consumed in the middle of a sequence abandons that sequence. No strobe is issued for it, and the new command runs normally.
- R13: A command byte other than 0x80 to 0x84 returns the sequencer to `S_IDLE` and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Host port select: 0 data, 1 status/command, 2 interrupt control |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for the selected port (combinational) |
| evt_raise | input | NUM_EVENTS | Per-event set pulses |
| smi_raise | input | 1 | Pulse that sets the system-management pending flag |
| reg_addr | output | 8 | Register space address |
| reg_wdata | output | 8 | Register space write data |
| reg_we | output | 1 | Register space write strobe |
| reg_re | output | 1 | Register space read strobe |
| reg_rdata | input | 8 | Register space read data, valid in the cycle `reg_re` is high |
| sci_irq | output | 1 | Event interrupt request |
| smi_irq | output | 1 | System-management interrupt request |

## Verification
Faults in the sequencer show up as the wrong strobe on the register interface. A missing strobe, an extra strobe, or a strobe with the wrong address appears within `PROC_DLY`+1 cycles of the byte that should have caused it, and a later host read returns a value that does not match the shadow copy of the register space. Errors in the input-full or output-full timing show up at once in the status byte. A host that polls those flags then either hangs, which the watchdog catches, or sends bytes that are dropped. Errors in the event queue appear in the next query result and in status bit 5.

// File: rtl/ec_pkg.sv
package ec_pkg;
    localparam logic [7:0] CMD_READ      = 8'h80;
    localparam logic [7:0] CMD_WRITE     = 8'h81;
    localparam logic [7:0] CMD_BURST_ON  = 8'h82;
    localparam logic [7:0] CMD_BURST_OFF = 8'h83;
    localparam logic [7:0] CMD_QUERY     = 8'h84;

    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_ICR  = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ADDR,
        S_RD_FETCH,
        S_WR_ADDR,
        S_WR_DATA
    } seq_state_t;
endpackage

// File: rtl/ec_ibf_timer.sv
module ec_ibf_timer #(
    parameter int PROC_DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    output logic ibf,
    output logic consume
);
    localparam int CW = (PROC_DLY < 2) ? 1 : $clog2(PROC_DLY);
    localparam logic [CW-1:0] LOAD = CW'(PROC_DLY - 1);

    logic [CW-1:0] cnt;

    assign consume = ibf && (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibf <= 1'b0;
            cnt <= '0;
        end else if (!ibf && accept) begin
            ibf <= 1'b1;
            cnt <= LOAD;
        end else if (consume) begin
            ibf <= 1'b0;
        end else if (ibf) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/ec_event_queue.sv
module ec_event_queue #(
    parameter int NUM_EVENTS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] raise,
    input  logic                  pop,
    output logic                  any,
    output logic [7:0]            code
);
    logic [NUM_EVENTS-1:0] pend;
    logic [NUM_EVENTS-1:0] lowest;

    assign lowest = pend & (~pend + 1'b1);
    assign any    = |pend;

    always_comb begin
        code = 8'd0;
        for (int i = 0; i < NUM_EVENTS; i++) begin
            if (lowest[i]) code = 8'(i + 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~(pop ? lowest : '0)) | raise;
    end
endmodule

// File: rtl/ec_cmd_fsm.sv
module ec_cmd_fsm
    import ec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       consume,
    input  logic [7:0] in_byte,
    input  logic       in_cmd,
    input  logic [7:0] reg_rdata,
    input  logic [7:0] evt_code,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    output logic       reg_re,
    output logic       burst,
    output logic       load_req,
    output logic [7:0] load_val,
    output logic       evt_pop
);
    seq_state_t state, nxt;

    logic take_cmd, take_data, is_query;

    assign take_cmd  = consume && in_cmd;
    assign take_data = consume && !in_cmd;
    assign is_query  = take_cmd && (in_byte == CMD_QUERY);

    always_comb begin
        nxt = state;
        if (take_cmd) begin
            unique case (in_byte)
                CMD_READ:  nxt = S_RD_ADDR;
                CMD_WRITE: nxt = S_WR_ADDR;
                default:   nxt = S_IDLE;
            endcase
        end else if (take_data) begin
            unique case (state)
                S_RD_ADDR: nxt = S_RD_FETCH;
                S_WR_ADDR: nxt = S_WR_DATA;
                S_WR_DATA: nxt = S_IDLE;
                default:   nxt = state;
            endcase
        end else if (state == S_RD_FETCH) begin
            nxt = S_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_addr  <= 8'd0;
            reg_wdata <= 8'd0;
            reg_we    <= 1'b0;
            reg_re    <= 1'b0;
            burst     <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            reg_re <= 1'b0;
            if (take_data) begin
                unique case (state)
                    S_RD_ADDR: begin
                        reg_addr <= in_byte;
                        reg_re   <= 1'b1;
                    end
                    S_WR_ADDR: reg_addr <= in_byte;
                    S_WR_DATA: begin
                        reg_wdata <= in_byte;
                        reg_we    <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (take_cmd) begin
                if (in_byte == CMD_BURST_ON)  burst <= 1'b1;
                if (in_byte == CMD_BURST_OFF) burst <= 1'b0;
            end
        end
    end

    assign load_req = (state == S_RD_FETCH) || is_query;
    assign load_val = (state == S_RD_FETCH) ? reg_rdata : evt_code;
    assign evt_pop  = is_query;
endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
    import ec_pkg::*;
#(
    parameter int PROC_DLY   = 3,
    parameter int NUM_EVENTS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            host_sel,
    input  logic                  host_wr,
    input  logic                  host_rd,
    input  logic [7:0]            host_wdata,
    output logic [7:0]            host_rdata,
    input  logic [NUM_EVENTS-1:0] evt_raise,
    input  logic                  smi_raise,
    output logic [7:0]            reg_addr,
    output logic [7:0]            reg_wdata,
    output logic                  reg_we,
    output logic                  reg_re,
    input  logic [7:0]            reg_rdata,
    output logic                  sci_irq,
    output logic                  smi_irq
);
    logic       ibf, consume, accept;
    logic [7:0] in_byte;
    logic       in_cmd;
    logic       obf;
    logic [7:0] data_q;
    logic [1:0] icr_en;
    logic       smi_pend;
    logic       burst, load_req, evt_pop, evt_any;
    logic [7:0] load_val, evt_code;
    logic [7:0] status;
    logic       icr_wr;

    assign accept = host_wr && (host_sel == SEL_DATA || host_sel == SEL_CTRL);
    assign icr_wr = host_wr && (host_sel == SEL_ICR);

    ec_ibf_timer #(.PROC_DLY(PROC_DLY)) u_timer (
        .clk(clk), .rst_n(rst_n), .accept(accept), .ibf(ibf), .consume(consume)
    );

    ec_event_queue #(.NUM_EVENTS(NUM_EVENTS)) u_events (
        .clk(clk), .rst_n(rst_n), .raise(evt_raise), .pop(evt_pop),
        .any(evt_any), .code(evt_code)
    );

    ec_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .consume(consume), .in_byte(in_byte),
        .in_cmd(in_cmd), .reg_rdata(reg_rdata), .evt_code(evt_code),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .burst(burst), .load_req(load_req),
        .load_val(load_val), .evt_pop(evt_pop)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_byte <= 8'd0;
            in_cmd  <= 1'b0;
        end else if (accept && !ibf) begin
            in_byte <= host_wdata;
            in_cmd  <= (host_sel == SEL_CTRL);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= 8'd0;
            obf    <= 1'b0;
        end else if (load_req) begin
            data_q <= load_val;
            obf    <= 1'b1;
        end else if (host_rd && host_sel == SEL_DATA) begin
            obf    <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            icr_en   <= 2'd0;
            smi_pend <= 1'b0;
        end else begin
            if (icr_wr) icr_en <= host_wdata[1:0];
            if (smi_raise)                    smi_pend <= 1'b1;
            else if (icr_wr && host_wdata[2]) smi_pend <= 1'b0;
        end
    end

    assign status = {1'b0, smi_pend, evt_any, burst, in_cmd, 1'b0, ibf, obf};

    always_comb begin
        unique case (host_sel)
            SEL_DATA: host_rdata = data_q;
            SEL_CTRL: host_rdata = status;
            SEL_ICR:  host_rdata = {6'd0, icr_en};
            default:  host_rdata = 8'd0;
        endcase
    end

    assign sci_irq = evt_any && icr_en[0];
    assign smi_irq = smi_pend && icr_en[1];
endmodule

// File: rtl/ec_host_port_checker.sv
module ec_host_port_checker #(
    parameter int PROC_DLY = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ibf,
    input logic       obf,
    input logic       load_req,
    input logic       host_rd,
    input logic [1:0] host_sel,
    input logic       reg_we,
    input logic       reg_re,
    input logic       burst,
    input logic       sci_irq,
    input logic       sci_en
);
    logic [15:0] ibf_run;

    always_ff @(posedge clk) begin
        if (!rst_n)   ibf_run <= 16'd0;
        else if (ibf) ibf_run <= ibf_run + 16'd1;
        else          ibf_run <= 16'd0;
    end

    assert_ibf_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ibf |-> (ibf_run < 16'(PROC_DLY)));

    assert_read_after_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> $past(ibf));

    assert_load_sets_obf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> obf);

    assert_obf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_sel == 2'd0 && !load_req) |=> !obf);

    assert_write_after_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(ibf));

    assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));

    assert_burst_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ibf) |-> $stable(burst));

    assert_sci_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sci_irq |-> sci_en);
endmodule

bind ec_host_port ec_host_port_checker #(.PROC_DLY(PROC_DLY)) u_chk (
    .clk(clk), .rst_n(rst_n), .ibf(ibf), .obf(obf), .load_req(load_req),
    .host_rd(host_rd), .host_sel(host_sel), .reg_we(reg_we), .reg_re(reg_re),
    .burst(burst), .sci_irq(sci_irq), .sci_en(icr_en[0])
);

// File: tb/ec_host_port_bench.sv
module ec_host_port_bench;
    localparam int PD = 3;
    localparam int NE = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    host_sel = 2'd0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [7:0]    host_wdata = 8'd0;
    logic [7:0]    host_rdata;
    logic [NE-1:0] evt_raise = '0;
    logic          smi_raise = 1'b0;
    logic [7:0]    reg_addr, reg_wdata, reg_rdata;
    logic          reg_we, reg_re, sci_irq, smi_irq;

    int total = 0;
    int failed = 0;
    int we_cnt = 0;
    int re_cnt = 0;
    logic [7:0] mem [256];
    logic [7:0] shadow [256];

    always #10 clk = ~clk;

    ec_host_port #(.PROC_DLY(PD), .NUM_EVENTS(NE)) u_ec_host_port (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .evt_raise(evt_raise), .smi_raise(smi_raise), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata), .sci_irq(sci_irq), .smi_irq(smi_irq)
    );

    function automatic logic [7:0] init_val(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
        end else begin
            if (reg_we) begin
                mem[reg_addr] <= reg_wdata;
                we_cnt <= we_cnt + 1;
            end
            if (reg_re) re_cnt <= re_cnt + 1;
        end
    end
    assign reg_rdata = mem[reg_addr];

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [1:0] s, output logic [7:0] v);
        host_sel = s;
        #2;
        v = host_rdata;
    endtask

    task automatic host_write(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        host_sel = s; host_wdata = v; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        host_sel = s; host_rd = 1'b1;
        #2;
        v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_flag(input int bitpos, input logic want);
        logic [7:0] st;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            peek(2'd1, st);
            if (st[bitpos] == want) return;
        end
    endtask

    task automatic send(input logic [1:0] s, input logic [7:0] v);
        wait_flag(1, 1'b0);
        host_write(s, v);
    endtask

    task automatic ec_read(input logic [7:0] a, output logic [7:0] v);
        send(2'd1, 8'h80);
        send(2'd0, a);
        wait_flag(0, 1'b1);
        host_read(2'd0, v);
    endtask

    task automatic ec_write(input logic [7:0] a, input logic [7:0] d);
        send(2'd1, 8'h81);
        send(2'd0, a);
        send(2'd0, d);
        wait_flag(1, 1'b0);
        repeat (2) @(negedge clk);
    endtask

    task automatic ec_query(output logic [7:0] v);
        send(2'd1, 8'h84);
        wait_flag(0, 1'b1);
        host_read(2'd0, v);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v, st;
        int n, w0, r0;
        for (int i = 0; i < 256; i++) shadow[i] = init_val(i);
        void'($urandom(32'h1234ABCD));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(2'd1, st); check("R1 status", st, 0);
        peek(2'd0, v);  check("R1 data", v, 0);
        peek(2'd2, v);  check("R1 icr", v, 0);
        check("R1 irqs", {sci_irq, smi_irq}, 0);

        // R2 input-full width, R3 command bit, R7 burst on
        host_write(2'd1, 8'h82);
        n = 0;
        for (int k = 0; k < 20; k++) begin
            peek(2'd1, st);
            if (!st[1]) break;
            if (k == 0) check("R3 cmd bit", st[3], 1);
            n++;
            @(negedge clk);
        end
        check("R2 ibf cycles", n, PD);
        peek(2'd1, st); check("R7 burst set", st[4], 1);
        send(2'd1, 8'h83);
        wait_flag(1, 1'b0);
        peek(2'd1, st); check("R7 burst cleared", st[4], 0);

        // R11 stray data byte in idle
        w0 = we_cnt; r0 = re_cnt;
        send(2'd0, 8'h77);
        peek(2'd1, st); check("R3 data bit", st[3], 0);
        wait_flag(1, 1'b0);
        repeat (2) @(negedge clk);
        check("R11 no strobe", (we_cnt - w0) + (re_cnt - r0), 0);
        peek(2'd1, st); check("R11 obf unchanged", st[0], 0);

        // R2 byte dropped while input-full, then R6 write goes through
        w0 = we_cnt;
        send(2'd1, 8'h81);
        host_write(2'd0, 8'h33);
        send(2'd0, 8'h40);
        send(2'd0, 8'hC7);
        wait_flag(1, 1'b0);
        repeat (2) @(negedge clk);
        shadow[8'h40] = 8'hC7;
        check("R2 dropped byte, one write", we_cnt - w0, 1);
        check("R6 stored", mem[8'h40], 8'hC7);
        check("R2 dropped addr untouched", mem[8'h33], shadow[8'h33]);

        // R4 read and R5 obf clear
        r0 = re_cnt;
        ec_read(8'h40, v);
        check("R4 read value", v, 8'hC7);
        check("R4 one strobe", re_cnt - r0, 1);
        @(negedge clk);
        peek(2'd1, st); check("R5 obf cleared", st[0], 0);

        // R12 abort write with new read
        w0 = we_cnt;
        send(2'd1, 8'h81);
        send(2'd0, 8'h10);
        ec_read(8'h20, v);
        check("R12 read after abort", v, shadow[8'h20]);
        check("R12 no write", we_cnt - w0, 0);

        // R13 unknown command aborts
        send(2'd1, 8'h81);
        send(2'd0, 8'h11);
        send(2'd1, 8'h55);
        send(2'd0, 8'h99);
        wait_flag(1, 1'b0);
        repeat (2) @(negedge clk);
        check("R13 no write", we_cnt - w0, 0);
        peek(2'd1, st); check("R13 no output", st[0], 0);

        // R8/R9 events
        host_write(2'd2, 8'h01);
        @(negedge clk); evt_raise = 8'b0010_0100;
        @(negedge clk); evt_raise = '0;
        peek(2'd1, st); check("R9 sci pending", st[5], 1);
        check("R9 sci_irq", sci_irq, 1);
        ec_query(v); check("R8 first event", v, 3);
        peek(2'd1, st); check("R9 still pending", st[5], 1);
        ec_query(v); check("R8 second event", v, 6);
        peek(2'd1, st); check("R9 sci cleared", st[5], 0);
        check("R9 irq low", sci_irq, 0);
        ec_query(v); check("R8 empty query", v, 0);

        // R10 smi
        @(negedge clk); smi_raise = 1'b1;
        @(negedge clk); smi_raise = 1'b0;
        peek(2'd1, st); check("R10 smi bit", st[6], 1);
        check("R10 smi gated", smi_irq, 0);
        host_write(2'd2, 8'h02);
        check("R10 smi_irq", smi_irq, 1);
        host_write(2'd2, 8'h06);
        peek(2'd1, st); check("R10 smi cleared", st[6], 0);
        peek(2'd2, v); check("R10 icr readback", v, 2);

        // R6/R4 random traffic against shadow
        for (int t = 0; t < 30; t++) begin
            logic [7:0] a, d;
            a = 8'($urandom); d = 8'($urandom);
            w0 = we_cnt;
            ec_write(a, d);
            shadow[a] = d;
            check("R6 random one write", we_cnt - w0, 1);
            a = 8'($urandom);
            ec_read(a, v);
            check("R4 random read", v, shadow[a]);
        end

        finish_run();
    end
endmodule